// File: doc/BRIEF.md
# Streaming complex baseband low-pass FIR

This block low-pass filters a stream of complex baseband samples. Every clock cycle can carry one sample, made of a signed in-phase word and a signed quadrature word, marked by an input strobe. Both components pass through two identical filter channels that share one fixed set of real coefficients. The two channels never mix. Each accepted sample produces exactly one filtered sample, which leaves the block after a fixed number of cycles together with an output strobe. Downstream logic is expected to take every output as it appears, because there is no backpressure.

The coefficients form a linear-phase, odd-length windowed-sinc low-pass filter with a Blackman window. They are computed from the parameters when the design is elaborated and stored as constants. Because the taps are mirror-symmetric, the two samples that meet the same coefficient are added before the multiply, so each channel needs only (N+1)/2 multiplies per sample. The group delay is (N-1)/2 samples, which is 64 samples at the default length of 129 taps. The default design point places a 250 kHz cutoff in a 2.4 MHz sample stream.

Top module: `iq_fir_lpf`

## Requirements
- R1: A sample taken on the rising edge where `in_valid` is high comes out with `out_valid` high after the third rising edge that follows. The fixed pipeline latency is 4 register stages, counting the capture edge.
- R2: A cycle with `in_valid` low does not shift the delay line and produces no output. The values on `in_i` and `in_q` during such a cycle have no effect on any later output, and `out_i`/`out_q` hold their last value.
- R3: The coefficients are c[k] = floor(h[k]/S·2^17 + 0.5) for k = 0..N-1, stored as 18-bit signed values with 17 fractional bits. Here h[k] = 2r·sinc(2r·(k-(N-1)/2))·w[k], with r = 250e3/2.4e6, w the Blackman window 0.42 - 0.5cos(2πk/(N-1)) + 0.08cos(4πk/(N-1)), and S the sum of all h. As a result c[k] = c[N-1-k].
- R4: The in-phase and quadrature channels use the same coefficients and are independent: a channel whose input stays zero outputs zero whatever the other channel carries.
- R5: Each output is y = sat16(floor((Σk c[k]·x[n-k] + 2^16) / 2^17)), where x[n-k] is the sample accepted k strobes earlier and is zero before reset. A single impulse of amplitude A therefore yields round(A·c[k]/2^17) for k = 0..N-1, then zeros.
- R6: A constant input held for more than N samples gives an output within 8 LSB of that constant.
- R7: The accumulation is exact, with no internal wrap. A result beyond the 16-bit signed range is clamped to 32767 or -32768.
- R8: Synchronous reset clears the delay line, all pipeline strobes and both output words to zero. Outputs after reset are computed as if every earlier sample were zero.
- R9: The impulse response peaks at output index (N-1)/2 = 64 after the impulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Filtered in-phase sample, signed |
| out_q | output | 16 | Filtered quadrature sample, signed |

## Verification
The bench drives on the falling edge and records, for each accepted sample, the cycle count at which its result is due. That cycle is the capture edge plus three more rising edges. The monitor samples on the falling edge and fails any result that shows up in a different cycle, any strobe with nothing outstanding, and any due result that never arrives. Expected words come from a direct-form convolution over the bench's own sample history, with the coefficients built from the stated formula. This matches R5 and the impulse, DC, saturation and reset cases exactly. Junk data is driven in gap cycles so that any leak into the filter state shows up in later results.

// File: rtl/iq_fir_pkg.sv
package iq_fir_pkg;

  localparam int  DEF_NTAPS     = 129;
  localparam int  DEF_DW        = 16;
  localparam int  DEF_CW        = 18;
  localparam int  DEF_CFRAC     = 17;
  localparam real DEF_CUT_RATIO = 250.0e3 / 2.4e6;
  localparam real PI_C          = 3.14159265358979323846;

  // Blackman window weight at index k of an n-point window
  function automatic real blackman_w(int n, int k);
    real a;
    a = 2.0 * PI_C * k / (n - 1);
    return 0.42 - 0.5 * $cos(a) + 0.08 * $cos(2.0 * a);
  endfunction

  // unscaled windowed-sinc tap, r = cutoff / sample rate
  function automatic real proto_tap(int n, int k, real r);
    real m;
    real x;
    m = k - (n - 1) / 2.0;
    x = 2.0 * r * m;
    if (m == 0.0) return 2.0 * r * blackman_w(n, k);
    return 2.0 * r * ($sin(PI_C * x) / (PI_C * x)) * blackman_w(n, k);
  endfunction

  // tap normalised to unity DC gain and rounded to frac fraction bits
  function automatic int quant_tap(int n, int k, real r, int frac);
    real s;
    s = 0.0;
    for (int j = 0; j < n; j++) s = s + proto_tap(n, j, r);
    return $rtoi($floor(proto_tap(n, k, r) / s * (2.0 ** frac) + 0.5));
  endfunction

endpackage

// File: rtl/iq_tap_line.sv
module iq_tap_line #(
  parameter int NTAPS = iq_fir_pkg::DEF_NTAPS,
  parameter int DW    = iq_fir_pkg::DEF_DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] taps [NTAPS]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
    end else if (shift_en) begin
      taps[0] <= din;
      for (int k = 1; k < NTAPS; k++) taps[k] <= taps[k-1];
    end
  end

  // R2: a strobed sample lands at the head of the line
  p_insert_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps[0] == $past(din));
  // R2: the line moves one place per strobe
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps[1] == $past(taps[0]));
  // R2: no strobe, no movement
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps[0]) && $stable(taps[NTAPS-1]));

endmodule

// File: rtl/iq_fold_mac.sv
module iq_fold_mac #(
  parameter int  NTAPS     = iq_fir_pkg::DEF_NTAPS,
  parameter int  DW        = iq_fir_pkg::DEF_DW,
  parameter int  CW        = iq_fir_pkg::DEF_CW,
  parameter int  CFRAC     = iq_fir_pkg::DEF_CFRAC,
  parameter real CUT_RATIO = iq_fir_pkg::DEF_CUT_RATIO
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_fold,
  input  logic                 en_mul,
  input  logic                 en_out,
  input  logic signed [DW-1:0] taps [NTAPS],
  output logic signed [DW-1:0] y
);

  localparam int NFOLD = (NTAPS + 1) / 2;
  localparam int MID   = (NTAPS - 1) / 2;
  localparam int PW    = DW + 1;
  localparam int MW    = PW + CW;
  localparam int AW    = MW + $clog2(NFOLD) + 1;

  localparam logic signed [AW-1:0] HALF = AW'(1) << (CFRAC - 1);
  localparam logic signed [AW-1:0] YMAX = (AW'(1) << (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

  function automatic logic [NFOLD*CW-1:0] pack_coefs();
    logic [NFOLD*CW-1:0] r;
    r = '0;
    for (int k = 0; k < NFOLD; k++)
      r[k*CW +: CW] = CW'(iq_fir_pkg::quant_tap(NTAPS, k, CUT_RATIO, CFRAC));
    return r;
  endfunction

  localparam logic [NFOLD*CW-1:0] COEFS = pack_coefs();

  // round half up, drop the fraction, clamp to the output range
  function automatic logic signed [DW-1:0] round_sat(logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    r = (a + HALF) >>> CFRAC;
    if (r > YMAX) return YMAX[DW-1:0];
    if (r < YMIN) return YMIN[DW-1:0];
    return r[DW-1:0];
  endfunction

  logic signed [PW-1:0] fold_n [NFOLD];
  logic signed [PW-1:0] fold_q [NFOLD];
  logic signed [MW-1:0] prod_q [NFOLD];
  logic signed [AW-1:0] acc;

  for (genvar k = 0; k < NFOLD; k++) begin : g_fold
    if (k == MID) begin : g_centre
      assign fold_n[k] = {taps[k][DW-1], taps[k]};
    end else begin : g_pair
      assign fold_n[k] = {taps[k][DW-1], taps[k]}
                       + {taps[NTAPS-1-k][DW-1], taps[NTAPS-1-k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NFOLD; k++) begin
        fold_q[k] <= '0;
        prod_q[k] <= '0;
      end
    end else begin
      if (en_fold)
        for (int k = 0; k < NFOLD; k++) fold_q[k] <= fold_n[k];
      if (en_mul)
        for (int k = 0; k < NFOLD; k++)
          prod_q[k] <= MW'(fold_q[k]) * MW'($signed(COEFS[k*CW +: CW]));
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NFOLD; k++) acc = acc + AW'(prod_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst)         y <= '0;
    else if (en_out) y <= round_sat(acc);
  end

  // R2: output word only changes on a result strobe
  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en_out |=> $stable(y));
  // R2: folded sums only change when a new sample entered the line
  p_fold_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en_fold |=> $stable(fold_q[MID]));

endmodule

// File: rtl/iq_fir_lpf.sv
module iq_fir_lpf
  import iq_fir_pkg::*;
#(
  parameter int  NTAPS     = DEF_NTAPS,
  parameter int  DW        = DEF_DW,
  parameter int  CW        = DEF_CW,
  parameter int  CFRAC     = DEF_CFRAC,
  parameter real CUT_RATIO = DEF_CUT_RATIO
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int PIPE_LAT = 4;  // capture, fold, multiply, sum/round
  localparam int NCH      = 2;

  logic [PIPE_LAT-1:0]  vpipe;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[PIPE_LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[PIPE_LAT-1];
  assign ch_in[0]  = in_i;
  assign ch_in[1]  = in_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic signed [DW-1:0] line [NTAPS];

    iq_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
      .clk     (clk),
      .rst     (rst),
      .shift_en(in_valid),
      .din     (ch_in[ch]),
      .taps    (line)
    );

    iq_fold_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .CFRAC(CFRAC),
                  .CUT_RATIO(CUT_RATIO)) u_mac (
      .clk    (clk),
      .rst    (rst),
      .en_fold(vpipe[0]),
      .en_mul (vpipe[1]),
      .en_out (vpipe[2]),
      .taps   (line),
      .y      (ch_out[ch])
    );
  end

  assign out_i = ch_out[0];
  assign out_q = ch_out[1];

  // R1: every result strobe traces back to an input strobe PIPE_LAT edges earlier
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, PIPE_LAT));

endmodule

// File: tb/iq_fir_lpf_bench.sv
`timescale 1ns/1ps
module iq_fir_lpf_bench;

  localparam int  NT    = 129;
  localparam int  MIDT  = (NT - 1) / 2;
  localparam real RATIO = 250.0e3 / 2.4e6;
  localparam real PIV   = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  iq_fir_lpf u_iq_fir_lpf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #2.5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ntot = 0;
  int nbad = 0;
  int ctap [NT];
  int hi [NT];
  int hq [NT];
  bit cap = 1'b0;
  int obs_i [$];
  int obs_q [$];
  int last_i = 0;
  int last_q = 0;

  typedef struct {
    int          ei;
    int          eq;
    int unsigned ecyc;
    string       tag;
  } item_t;
  item_t sb [$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // R3: coefficients from the stated windowed-sinc formula
  function automatic void build_taps();
    real h [NT];
    real s;
    s = 0.0;
    for (int k = 0; k < NT; k++) begin
      real m;
      real x;
      real w;
      m = k - (NT - 1) / 2.0;
      x = 2.0 * RATIO * m;
      w = 0.42 - 0.5 * $cos(2.0 * PIV * k / (NT - 1))
               + 0.08 * $cos(2.0 * (2.0 * PIV * k / (NT - 1)));
      if (m == 0.0) h[k] = 2.0 * RATIO * w;
      else          h[k] = 2.0 * RATIO * ($sin(PIV * x) / (PIV * x)) * w;
      s = s + h[k];
    end
    for (int k = 0; k < NT; k++)
      ctap[k] = $rtoi($floor(h[k] / s * (2.0 ** 17) + 0.5));
  endfunction

  // R5/R7: direct-form reference, exact sum, round half up, clamp
  function automatic int ref_out(input int hist [NT]);
    longint acc;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(ctap[k]) * longint'(hist[k]);
    acc = (acc + 65536) >>> 17;
    if (acc > 32767)  return 32767;
    if (acc < -32768) return -32768;
    return int'(acc);
  endfunction

  // called on a falling edge; drives one strobed sample, then gap idle cycles
  task automatic send(int xi, int xq, string tag, int gap);
    item_t it;
    for (int k = NT - 1; k > 0; k--) begin
      hi[k] = hi[k-1];
      hq[k] = hq[k-1];
    end
    hi[0] = xi;
    hq[0] = xq;
    it.ei   = ref_out(hi);
    it.eq   = ref_out(hq);
    it.ecyc = cyc + 4;  // R1: capture edge plus three edges
    it.tag  = tag;
    sb.push_back(it);
    in_valid = 1'b1;
    in_i = 16'(xi);
    in_q = 16'(xq);
    @(negedge clk);
    if (gap > 0) begin
      in_valid = 1'b0;
      repeat (gap) begin
        in_i = 16'($urandom);  // R2: junk while idle
        in_q = 16'($urandom);
        @(negedge clk);
      end
    end
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    sb.delete();
    for (int k = 0; k < NT; k++) begin
      hi[k] = 0;
      hq[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "out_valid with nothing outstanding", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc == it.ecyc, "R1", "result cycle", cyc, it.ecyc);
          check(int'(out_i) == it.ei, it.tag, "out_i", out_i, it.ei);
          check(int'(out_q) == it.eq, it.tag, "out_q", out_q, it.eq);
          last_i = out_i;
          last_q = out_q;
          if (cap) begin
            obs_i.push_back(out_i);
            obs_q.push_back(out_q);
          end
        end
      end else if (sb.size() > 0 && sb[0].ecyc <= cyc) begin
        check(1'b0, "R1", "missing result at cycle", cyc, sb[0].ecyc);
        void'(sb.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    build_taps();
    for (int k = 0; k < NT; k++) begin
      hi[k] = 0;
      hq[k] = 0;
    end
    @(negedge clk);
    do_reset();

    // R8: reset state
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(out_i == 16'sd0, "R8", "out_i after reset", out_i, 0);
    check(out_q == 16'sd0, "R8", "out_q after reset", out_q, 0);

    // R5 R4: impulse of opposite extremes on the two channels
    cap = 1'b1;
    send(32767, -32768, "R5", 0);
    for (int n = 0; n < NT + 10; n++) send(0, 0, "R5", 0);
    idle(8);
    cap = 1'b0;
    begin
      int pk_i;
      int pk_q;
      bit sym;
      pk_i = 0;
      pk_q = 0;
      sym = 1'b1;
      for (int k = 0; k < NT; k++) begin
        if (obs_i[k] > obs_i[pk_i]) pk_i = k;
        if (obs_q[k] < obs_q[pk_q]) pk_q = k;
      end
      for (int k = 0; k < MIDT; k++)
        if (obs_i[k] != obs_i[NT-1-k]) sym = 1'b0;
      check(pk_i == MIDT, "R9", "I impulse peak index", pk_i, MIDT);
      check(pk_q == MIDT, "R9", "Q impulse peak index", pk_q, MIDT);
      check(sym, "R3", "impulse response symmetric", sym, 1);
      check(obs_i[NT] == 0, "R5", "response ends after N samples", obs_i[NT], 0);
    end

    // R4: one channel silent while the other is busy
    for (int n = 0; n < 60; n++) send(int'($signed(16'($urandom))), 0, "R4", n % 2);
    idle(8);

    // R6: DC settling with irregular strobes
    for (int n = 0; n < 300; n++) send(10000, -7000, "R6", n % 3);
    idle(8);
    check((last_i - 10000) <= 8 && (10000 - last_i) <= 8, "R6", "I DC level", last_i, 10000);
    check((last_q + 7000) <= 8 && (-7000 - last_q) <= 8, "R6", "Q DC level", last_q, -7000);

    // R2 R5: varied data with gaps of 0..3 idle cycles carrying junk
    for (int n = 0; n < 400; n++)
      send(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R2", $urandom_range(0, 3));
    idle(8);

    // R7: sign-matched full-scale history drives both clamps
    for (int j = NT - 1; j >= 0; j--) begin
      int vi;
      vi = (ctap[j] > 0) ? 32767 : ((ctap[j] < 0) ? -32768 : 0);
      send(vi, (ctap[j] > 0) ? -32768 : ((ctap[j] < 0) ? 32767 : 0), "R7", 0);
    end
    idle(8);
    check(last_i == 32767, "R7", "positive clamp", last_i, 32767);
    check(last_q == -32768, "R7", "negative clamp", last_q, -32768);

    // R8: reset in mid-stream, history must restart from zero
    for (int n = 0; n < 50; n++) send(20000, -20000, "R8", 0);
    in_valid = 1'b0;
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after mid-stream reset", out_valid, 0);
    check(out_i == 16'sd0, "R8", "out_i after mid-stream reset", out_i, 0);
    for (int n = 0; n < 20; n++) send(1000 * (n % 5), -300 * n, "R8", n % 2);
    idle(8);
    check(sb.size() == 0, "R1", "results outstanding at end", sb.size(), 0);

    finish_run();
  end

endmodule